// File: doc/BRIEF.md
# Two-Channel Packet Transmit Arbiter

This block decides which of two packet sources drives one outgoing link transmitter. Source 0 carries responses that the node generates automatically for remote memory accesses, and source 1 carries transmissions the user has asked for. Each source offers bytes on a valid/ready stream with a last-byte flag. The output is a single stream of the same kind.

The arbiter picks a winner only between packets. Once it has picked one, the whole packet, up to and including the flagged last byte, goes through before the other source can be served. When both sources are waiting, source 0 always wins. No fairness mechanism is included, so steady traffic on source 0 can hold off source 1 indefinitely.

The controller has three states. `IDLE` forwards nothing. `SERVE_RSP` forwards source 0. `SERVE_USR` forwards source 1. It has three transitions. PICK_RSP goes from `IDLE` to `SERVE_RSP` when source 0 is valid. PICK_USR goes from `IDLE` to `SERVE_USR` when only source 1 is valid. RELEASE goes from either serving state back to `IDLE` in the cycle after the last byte has been accepted downstream. Every packet is therefore followed by one idle cycle.

Top module: `tx_pkt_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, out_valid, rsp_ready and usr_ready are all low.
- R2: While the arbiter is idle, out_valid, rsp_ready and usr_ready are low, whatever the inputs are.
- R3: If rsp_valid is high in an idle cycle, source 0 is served from the next cycle, even when usr_valid is also high.
- R4: If usr_valid is high and rsp_valid is low in an idle cycle, source 1 is served from the next cycle.
- R5: While a source is served, out_valid, out_data and out_last equal that source's valid, data and last. That source's ready equals out_ready in the same cycle.
- R6: The source that is not being served sees its ready held low.
- R7: A grant ends only on the cycle in which out_valid, out_ready and out_last are all high. The cycle after that is idle.
- R8: rsp_valid rising while source 1 is being served does not interrupt the packet from source 1.
- R9: A last byte that is offered while out_ready is low does not end the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Source 0 (responses) byte valid |
| rsp_ready | output | 1 | Source 0 byte accepted |
| rsp_data | input | DATA_W | Source 0 byte |
| rsp_last | input | 1 | Source 0 last byte of packet |
| usr_valid | input | 1 | Source 1 (user) byte valid |
| usr_ready | output | 1 | Source 1 byte accepted |
| usr_data | input | DATA_W | Source 1 byte |
| usr_last | input | 1 | Source 1 last byte of packet |
| out_valid | output | 1 | Link byte valid |
| out_ready | input | 1 | Link accepts byte |
| out_data | output | DATA_W | Link byte |
| out_last | output | 1 | Link last byte of packet |

## Verification
The assertions assume that each source obeys the usual stream rule: once valid is raised, it stays high, with data and last held steady, until the byte is accepted. The assertions also assume that every input carries a known value once reset is released. The random sources in the bench keep to this rule. A source raises valid only when it has no pending byte, and it keeps each pending byte unchanged until the handshake cycle. The downstream ready signal and the rate of last bytes are varied from phase to phase, so that stalled last bytes and long runs from source 0 both occur.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SERVE_RSP = 2'd1,
        ST_SERVE_USR = 2'd2
    } arb_state_t;
endpackage

// File: rtl/tx_arb_fsm.sv
module tx_arb_fsm
    import tx_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_rsp,
    input  logic       req_usr,
    input  logic       pkt_done,
    output arb_state_t state
);
    arb_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_rsp)      state_nx = ST_SERVE_RSP;  // PICK_RSP
                else if (req_usr) state_nx = ST_SERVE_USR;  // PICK_USR
            end
            ST_SERVE_RSP: if (pkt_done) state_nx = ST_IDLE; // RELEASE
            ST_SERVE_USR: if (pkt_done) state_nx = ST_IDLE; // RELEASE
            default:      state_nx = ST_IDLE;
        endcase
    end

    // R3: response source wins from idle
    assert_rsp_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_rsp) |=> (state == ST_SERVE_RSP));
    // R4: user source served when it requests alone
    assert_usr_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req_rsp && req_usr) |=> (state == ST_SERVE_USR));
    // R7, R8, R9: grant holds until the packet is finished
    assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !pkt_done) |=> $stable(state));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && pkt_done) |=> (state == ST_IDLE));
endmodule

// File: rtl/tx_arb_route.sv
module tx_arb_route
    import tx_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  arb_state_t        state,
    input  logic [1:0]        src_valid,
    input  logic [1:0]        src_last,
    input  logic [DATA_W-1:0] src_data [2],
    output logic [1:0]        src_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    logic [1:0] sel;

    always_comb begin
        sel = 2'b00;
        unique case (state)
            ST_SERVE_RSP: sel = 2'b01;
            ST_SERVE_USR: sel = 2'b10;
            default:      sel = 2'b00;
        endcase
    end

    for (genvar i = 0; i < 2; i++) begin : g_rdy
        assign src_ready[i] = sel[i] & out_ready;
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (sel[i]) begin
                out_valid = src_valid[i];
                out_data  = src_data[i];
                out_last  = src_last[i];
            end
        end
    end
endmodule

// File: rtl/tx_pkt_arbiter.sv
module tx_pkt_arbiter
    import tx_arb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_last,
    input  logic              usr_valid,
    output logic              usr_ready,
    input  logic [DATA_W-1:0] usr_data,
    input  logic              usr_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    arb_state_t        state;
    logic [1:0]        src_ready;
    logic [DATA_W-1:0] src_data [2];
    logic              pkt_done;

    assign src_data[0] = rsp_data;
    assign src_data[1] = usr_data;
    assign pkt_done    = out_valid & out_ready & out_last;
    assign rsp_ready   = src_ready[0];
    assign usr_ready   = src_ready[1];

    tx_arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_rsp  (rsp_valid),
        .req_usr  (usr_valid),
        .pkt_done (pkt_done),
        .state    (state)
    );

    tx_arb_route #(.DATA_W(DATA_W)) u_route (
        .state     (state),
        .src_valid ({usr_valid, rsp_valid}),
        .src_last  ({usr_last, rsp_last}),
        .src_data  (src_data),
        .src_ready (src_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // R2: idle forwards nothing
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!out_valid && !rsp_ready && !usr_ready));
    // R6: at most one source is given ready
    assert_ready_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && usr_ready));
    // R5: an accepted output byte is an accepted source byte
    assert_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (rsp_ready || usr_ready));
    // R1: first cycle after reset is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !rsp_ready && !usr_ready));
endmodule

// File: tb/tx_pkt_arbiter_tb_top.sv
module tx_pkt_arbiter_tb_top;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v0 = 0, l0 = 0, v1 = 0, l1 = 0, ordy = 0;
    logic [DW-1:0] d0 = '0, d1 = '0;
    logic r0, r1, ov, ol;
    logic [DW-1:0] od;

    int checks = 0;
    int errors = 0;
    int st = 0;          // model: 0 idle, 1 serving source 0, 2 serving source 1
    int p_v0 = 50, p_v1 = 50, p_rdy = 70, p_last = 30;
    bit acc0 = 0, acc1 = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tx_pkt_arbiter #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(v0), .rsp_ready(r0), .rsp_data(d0), .rsp_last(l0),
        .usr_valid(v1), .usr_ready(r1), .usr_data(d1), .usr_last(l1),
        .out_valid(ov), .out_ready(ordy), .out_data(od), .out_last(ol)
    );

    function automatic bit roll(int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string ctx);
        bit e_ov, e_ol, e_r0, e_r1;
        logic [DW-1:0] e_od;
        string tag;
        @(negedge clk);
        if (!v0 || acc0) begin
            v0 = roll(p_v0); d0 = DW'($urandom); l0 = roll(p_last);
        end
        if (!v1 || acc1) begin
            v1 = roll(p_v1); d1 = DW'($urandom); l1 = roll(p_last);
        end
        ordy = roll(p_rdy);
        #1;
        e_ov = 0; e_ol = 0; e_od = '0; e_r0 = 0; e_r1 = 0;
        if (st == 1) begin e_ov = v0; e_od = d0; e_ol = l0; e_r0 = ordy; end
        if (st == 2) begin e_ov = v1; e_od = d1; e_ol = l1; e_r1 = ordy; end
        tag = (st == 0) ? "R2" : ctx;
        chk(tag, "out_valid", DW'(ov), DW'(e_ov));
        if (e_ov) begin
            chk(tag, "out_data", od, e_od);
            chk(tag, "out_last", DW'(ol), DW'(e_ol));
        end
        chk(st == 1 ? "R5" : (st == 2 ? "R6" : "R2"), "rsp_ready", DW'(r0), DW'(e_r0));
        chk(st == 2 ? "R5" : (st == 1 ? "R6" : "R2"), "usr_ready", DW'(r1), DW'(e_r1));
        acc0 = v0 && e_r0;
        acc1 = v1 && e_r1;
        if (st == 0) begin
            if (v0) st = 1; else if (v1) st = 2;
        end else if (e_ov && ordy && e_ol) begin
            st = 0;
        end
    endtask

    // context tag from the model state before the cycle
    function automatic string ctx_tag(int pst, bit both, bit stall_eop, bit fin);
        if (fin) return "R7";
        if (stall_eop) return "R9";
        if (pst == 0 && st == 1) return "R3";
        if (pst == 0 && st == 2) return "R4";
        if (st == 2 && both) return "R8";
        return "R5";
    endfunction

    task automatic run(int n);
        int pst = 0;
        bit both = 0, stall = 0, fin = 0;
        for (int i = 0; i < n; i++) begin
            cycle(ctx_tag(pst, both, stall, fin));
            pst = st;
            both = v0;
            stall = (st != 0) && ((st == 1 && v0 && l0) || (st == 2 && v1 && l1)) && !ordy;
            fin = 0;
            if (pst == 0) fin = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        v0 = 1; v1 = 1; ordy = 1;
        #1;
        chk("R1", "out_valid in reset", DW'(ov), DW'(0));
        chk("R1", "rsp_ready in reset", DW'(r0), DW'(0));
        chk("R1", "usr_ready in reset", DW'(r1), DW'(0));
        v0 = 0; v1 = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "out_valid after reset", DW'(ov), DW'(0));
        chk("R1", "rsp_ready after reset", DW'(r0), DW'(0));
        // R3: both request together, source 0 wins
        p_v0 = 100; p_v1 = 100; p_rdy = 100; p_last = 50;
        run(40);
        // R4/R8: source 1 alone, then source 0 arrives mid-packet
        p_v0 = 0; p_v1 = 100; p_last = 10;
        run(3);
        p_v0 = 100;
        run(40);
        // R9: stalled last bytes
        p_v0 = 60; p_v1 = 60; p_rdy = 30; p_last = 60;
        run(400);
        // balanced random
        p_v0 = 40; p_v1 = 70; p_rdy = 70; p_last = 25;
        run(2000);
        // R7: heavy source 0, short packets
        p_v0 = 95; p_v1 = 95; p_rdy = 90; p_last = 80;
        run(500);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule